// File: doc/BRIEF.md
# Dual-Mode Fractional Clock Divider

This block turns a stream of input ticks into a slower stream of output events. It has an 8-bit working register, called the result, and an 8-bit step value, and it runs in one of two modes. In fractional mode the result acts as a phase accumulator. On every input tick the step is added to the result, and an output tick is emitted whenever that addition carries out of the top bit. The output then averages step/256 of the input rate, with at most one input period of jitter from ideal spacing.

In reload mode the same register becomes an auto-reload up-counter. It is seeded with the step when the block is enabled and advances by one per input tick. When it passes the all-ones value it reloads the step. Each such overflow raises a one-cycle interrupt pulse and sets a sticky overflow flag, which stays set until software clears it. In this mode the output tick stays low, and overflows occur once every 256 − step input ticks.

Control reaches the block through register-style inputs: an enable, a mode select, the step value, a result write port and a flag clear. The result value is always readable.

Top module: `frac_clkdiv`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared. After that edge, `result` is 0x00 and `tick_out`, `irq` and `ovf_flag` are all 0.
- R2: In fractional mode (`cfg_mode` = 0), each cycle with `cfg_en` = 1 and `tick_in` = 1 replaces `result` with (`result` + `cfg_step`) mod 256. Starting from 0x70 with step 0x8D, the first twelve values are FD, 8A, 17, A4, 31, BE, 4B, D8, 65, F2, 7F, 0C.
- R3: In fractional mode, `tick_out` is 1 for exactly the one cycle after an addition that carries out of bit 7. At all other times it is 0.
- R4: In fractional mode, any 256 consecutive input ticks with a fixed step produce exactly `cfg_step` output ticks, whatever the starting value.
- R5: A step of 0x00 in fractional mode never produces an output tick.
- R6: In reload mode (`cfg_mode` = 1), the first cycle with `cfg_en` = 1 after a cycle with `cfg_en` = 0 loads `cfg_step` into `result`, and any input tick in that cycle is dropped. After that, each input tick adds one to `result`.
- R7: In reload mode, an input tick that arrives while `result` is 0xFF reloads `cfg_step` and pulses `irq` for one cycle. `tick_out` stays 0 throughout reload mode.
- R8: In reload mode, successive `irq` pulses, and the load and the first pulse, are separated by exactly 256 − `cfg_step` input ticks.
- R9: `ovf_flag` is set by every overflow and stays set until `flag_clr` = 1. An overflow in the same cycle as a clear leaves the flag set.
- R10: While `cfg_en` = 0, `result` holds and `tick_out` and `irq` stay 0.
- R11: `res_wr` = 1 loads `res_wdata` into `result` on the next edge. This takes priority over loads, ticks and the enable.
- R12: While enabled, a cycle with `tick_in` = 0 leaves `result` unchanged and produces no tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Input tick (clock enable) |
| cfg_en | input | 1 | Block enable |
| cfg_mode | input | 1 | 0 = fractional, 1 = reload timer |
| cfg_step | input | 8 | Step / reload value |
| res_wr | input | 1 | Write strobe for result |
| res_wdata | input | 8 | Value written to result |
| flag_clr | input | 1 | Clears the overflow flag |
| result | output | 8 | Current accumulator / counter value |
| tick_out | output | 1 | Fractional-mode output tick |
| irq | output | 1 | One-cycle overflow interrupt pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Every output of this block is a register, so each result is due one edge after the edge that samples its stimulus. This holds for the new result value, the carry tick, the overflow pulse and the flag. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge, so each read lands exactly one edge after the stimulus. Reload periods are measured by counting input ticks from the load edge up to the edge that shows `irq`. Both the fractional and the reload sweeps cover all 256 step values, and the expected sums, carries and periods are computed arithmetically in the bench.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;
  localparam logic MODE_FRAC   = 1'b0;
  localparam logic MODE_RELOAD = 1'b1;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_SEED  = 2'd2,
    ACT_STEP  = 2'd3
  } fcd_action_e;
endpackage

// File: rtl/fcd_phase_acc.sv
`timescale 1ns/1ps
module fcd_phase_acc #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] step,
  output logic [W-1:0] sum,
  output logic         carry
);
  localparam int WX = W + 1;
  logic [WX-1:0] wide;

  always_comb begin
    wide  = {1'b0, acc} + {1'b0, step};
    sum   = wide[W-1:0];
    carry = wide[W];
  end
endmodule

// File: rtl/fcd_reload_ctr.sv
`timescale 1ns/1ps
module fcd_reload_ctr #(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] reload,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    wrap = &cnt;
    nxt  = wrap ? reload : cnt + ONE;
  end
endmodule

// File: rtl/fcd_sticky.sv
`timescale 1ns/1ps
module fcd_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/frac_clkdiv.sv
`timescale 1ns/1ps
module frac_clkdiv
  import fcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_in,
  input  logic         cfg_en,
  input  logic         cfg_mode,
  input  logic [W-1:0] cfg_step,
  input  logic         res_wr,
  input  logic [W-1:0] res_wdata,
  input  logic         flag_clr,
  output logic [W-1:0] result,
  output logic         tick_out,
  output logic         irq,
  output logic         ovf_flag
);
  logic         en_q;
  logic [W-1:0] acc_sum;
  logic         acc_carry;
  logic [W-1:0] ctr_nxt;
  logic         ctr_wrap;
  logic [W-1:0] res_nxt;
  logic         tick_nxt;
  logic         irq_nxt;
  fcd_action_e  act;

  fcd_phase_acc #(.W(W)) u_acc (
    .acc   (result),
    .step  (cfg_step),
    .sum   (acc_sum),
    .carry (acc_carry)
  );

  fcd_reload_ctr #(.W(W)) u_ctr (
    .cnt    (result),
    .reload (cfg_step),
    .nxt    (ctr_nxt),
    .wrap   (ctr_wrap)
  );

  always_comb begin
    if (res_wr)
      act = ACT_WRITE;
    else if (!cfg_en)
      act = ACT_HOLD;
    else if (cfg_mode == MODE_RELOAD && !en_q)
      act = ACT_SEED;
    else if (tick_in)
      act = ACT_STEP;
    else
      act = ACT_HOLD;
  end

  always_comb begin
    res_nxt  = result;
    tick_nxt = 1'b0;
    irq_nxt  = 1'b0;
    unique case (act)
      ACT_WRITE: res_nxt = res_wdata;
      ACT_SEED:  res_nxt = cfg_step;
      ACT_STEP: begin
        if (cfg_mode == MODE_FRAC) begin
          res_nxt  = acc_sum;
          tick_nxt = acc_carry;
        end else begin
          res_nxt  = ctr_nxt;
          irq_nxt  = ctr_wrap;
        end
      end
      default: res_nxt = result;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      tick_out <= 1'b0;
      irq      <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      result   <= res_nxt;
      tick_out <= tick_nxt;
      irq      <= irq_nxt;
      en_q     <= cfg_en;
    end
  end

  fcd_sticky u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (irq_nxt),
    .clr  (flag_clr),
    .flag (ovf_flag)
  );

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !res_wr) |=> ($stable(result) && !tick_out && !irq));
  // R3
  tick_src_chk: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> ($past(cfg_mode) == MODE_FRAC && $past(tick_in) && $past(cfg_en)));
  // R7
  irq_reload_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (result == $past(cfg_step) && !tick_out));
  // R5
  zero_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !res_wr && cfg_mode == MODE_FRAC && cfg_step == '0) |=> !tick_out);
  // R11
  write_load_chk: assert property (@(posedge clk) disable iff (rst)
    res_wr |=> (result == $past(res_wdata)));
  // R9
  flag_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_flag);
  // R7
  event_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tick_out, irq}));
endmodule

// File: tb/frac_clkdiv_tb.sv
`timescale 1ns/1ps
module frac_clkdiv_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_in = 1'b0;
  logic         cfg_en = 1'b0;
  logic         cfg_mode = 1'b0;
  logic [W-1:0] cfg_step = '0;
  logic         res_wr = 1'b0;
  logic [W-1:0] res_wdata = '0;
  logic         flag_clr = 1'b0;
  logic [W-1:0] result;
  logic         tick_out;
  logic         irq;
  logic         ovf_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  frac_clkdiv #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .cfg_en(cfg_en),
    .cfg_mode(cfg_mode), .cfg_step(cfg_step), .res_wr(res_wr),
    .res_wdata(res_wdata), .flag_clr(flag_clr), .result(result),
    .tick_out(tick_out), .irq(irq), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] m;
    logic         c;
    int cnt, bad, n, tk;

    // R1: reset state
    repeat (3) cyc();
    chk("R1 result", result, 0);
    chk("R1 tick_out", tick_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    rst = 1'b0;

    // R11 / R2 / R3: known sequence from 0x70 with step 0x8D
    cfg_mode = 1'b0;
    cfg_step = 8'h8D;
    res_wr = 1'b1; res_wdata = 8'h70;
    cyc();
    res_wr = 1'b0;
    chk("R11 write", result, 8'h70);
    cfg_en = 1'b1; tick_in = 1'b1;
    m = 8'h70;
    for (int i = 0; i < 12; i++) begin
      {c, m} = {1'b0, m} + {1'b0, cfg_step};
      cyc();
      chk("R2 frac sum", result, m);
      chk("R3 carry tick", tick_out, c);
    end
    chk("R2 final value", result, 8'h0C);

    // R12: sparse input ticks
    for (int i = 0; i < 15; i++) begin
      tick_in = (i % 3 == 0);
      c = 1'b0;
      if (tick_in) {c, m} = {1'b0, m} + {1'b0, cfg_step};
      cyc();
      chk("R12 gated sum", result, m);
      chk("R12 gated tick", tick_out, c);
    end

    // R10: disabled holds
    cfg_en = 1'b0; tick_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk("R10 hold", result, m);
      chk("R10 no tick", tick_out, 0);
    end

    // R4 / R5 / R2: fractional sweep over every step
    for (int s = 0; s < 256; s++) begin
      tick_in = 1'b0; cfg_en = 1'b1; cfg_mode = 1'b0;
      cfg_step = s[W-1:0];
      res_wr = 1'b1; res_wdata = s[W-1:0] ^ 8'h5A;
      cyc();
      res_wr = 1'b0;
      m = s[W-1:0] ^ 8'h5A;
      tick_in = 1'b1;
      cnt = 0; bad = 0;
      for (int k = 0; k < 256; k++) begin
        {c, m} = {1'b0, m} + {1'b0, cfg_step};
        cyc();
        if (tick_out) cnt++;
        if (result !== m || tick_out !== c) bad++;
      end
      chk("R4 tick count", cnt, s);
      chk("R2 sweep mismatches", bad, 0);
      if (s == 0) chk("R5 zero step ticks", cnt, 0);
    end

    // R6 / R7 / R8: reload sweep over every step
    cfg_mode = 1'b1;
    for (int s = 0; s < 256; s++) begin
      cfg_en = 1'b0; tick_in = 1'b0; cfg_step = s[W-1:0];
      cyc();
      cfg_en = 1'b1; tick_in = 1'b1;
      cyc();
      chk("R6 seed", result, s);
      tk = 0; bad = 0;
      for (int p = 0; p < 2; p++) begin
        n = 0;
        do begin
          cyc();
          n++;
          if (tick_out) tk++;
          if (!irq && result !== ((s + n) & 8'hFF)) bad++;
        end while (!irq && n < 300);
        chk("R8 period", n, 256 - s);
        chk("R7 reload value", result, s);
      end
      chk("R6 count up", bad, 0);
      chk("R7 no tick_out", tk, 0);
      chk("R9 flag set", ovf_flag, 1);
    end

    // R9: clear, set-wins, sticky
    cfg_en = 1'b0; tick_in = 1'b0; flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
    chk("R9 cleared", ovf_flag, 0);
    cfg_step = 8'hFE; cfg_en = 1'b1;
    cyc();
    chk("R6 seed FE", result, 8'hFE);
    tick_in = 1'b1;
    cyc();
    chk("R6 count FF", result, 8'hFF);
    chk("R9 not yet set", ovf_flag, 0);
    flag_clr = 1'b1;
    cyc();
    chk("R7 irq", irq, 1);
    chk("R9 set wins", ovf_flag, 1);
    tick_in = 1'b0; flag_clr = 1'b0;
    cyc();
    chk("R7 irq one cycle", irq, 0);
    chk("R9 sticky", ovf_flag, 1);
    chk("R12 reload hold", result, 8'hFE);
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
    chk("R9 clear", ovf_flag, 0);

    // R11: write beats tick while enabled
    tick_in = 1'b1; res_wr = 1'b1; res_wdata = 8'h33;
    cyc();
    res_wr = 1'b0; tick_in = 1'b0;
    chk("R11 write priority", result, 8'h33);
    chk("R11 no irq", irq, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule